// File: doc/BRIEF.md
# Chained Two-Buffer DMA Channel

This block is one DMA channel that moves 32-bit words between memory and a device, one word per accepted request. Software describes the active transfer with a pointer/limit pair. It can also park a second, follow-on buffer in a start/stop pair and arm it with a one-shot chain flag. When the pointer reaches the limit, the hardware does one of two things. If the flag is armed, it copies the follow-on buffer into the active pair, clears the flag and keeps running. If the flag is not armed, it turns itself off. In both cases it sets a completion flag, and that flag drives a level interrupt.

Each pair has a shadow copy that software loads together with the pair. On a chain switch the hardware moves the shadows of the follow-on pair into the shadows of the active pair. After an interrupt, software can then compare the stopped pointer with the shadow of the buffer's original start and work out how much data moved. A bus error from memory stops the channel on the failing word and records an exception flag. An elaboration option makes the limit carry a flag in its top bit and allow 15 bytes of trailing padding.

Software follows a fixed sequence. It writes zero to the control word, then writes init, reset and a direction together. Next it programs both pairs and their shadows. Last it enables the channel with the direction, adding the chain flag only when a follow-on buffer is valid. Each interrupt is acknowledged by a clear-complete write. That write can re-arm chaining, or it can carry reset to stop the channel.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the status word reads 0, `irq`, `mem_req` and `dev_tx_valid` are low, and every address register reads 0.
- R2: Register offsets on `reg_addr` are: 0 control/status, 1 pointer, 2 limit, 3 follow-on start, 4 follow-on stop, 5 pointer shadow, 6 limit shadow, 7 start shadow, 8 stop shadow, 9 pointer-with-init alias. Each address register reads back the last value written to it.
- R3: A write to offset 9 loads the pointer and clears the bus-exception flag in the same cycle. Offsets 1 and 9 read back the same pointer value.
- R4: Control writes decode bit 0 set-enable, bit 1 arm-chain, bit 2 clear-complete, bit 3 reset, bit 4 init (clears bus-exception), bit 5 set device-to-memory direction and bit 6 set memory-to-device direction. Reset clears enable, chain and complete and overrides set-enable and arm-chain in the same write. Status reads back bit 0 enable, bit 1 chain armed, bit 2 complete, bit 3 bus exception and bit 4 device-to-memory direction.
- R5: While enabled and the pointer differs from the end address, `mem_req` is high with `mem_addr` equal to the pointer. Each accepted word (`mem_ack` high with `mem_err` low) advances the pointer by 4, so words are issued in ascending address order.
- R6: In device-to-memory direction `mem_we` is high, `mem_wdata` equals `dev_rx_data` and `dev_rx_take` marks each accepted word. In memory-to-device direction `mem_we` is low, and in the cycle after acceptance `dev_tx_valid` is high with `dev_tx_data` holding that word's `mem_rdata`.
- R7: When the pointer reaches the end address while chaining is armed, the next edge loads pointer←start, limit←stop, pointer shadow←start shadow and limit shadow←stop shadow. It also clears the chain flag and sets complete, and the channel stays enabled.
- R8: When the pointer reaches the end address while chaining is not armed, the next edge clears enable and sets complete, and no further requests are made.
- R9: `mem_err` during a request sets bus exception and complete, clears enable and leaves the pointer on the failing word. That word is not counted as accepted.
- R10: `irq` is high exactly while the complete flag is set. It only rises while the channel is enabled, and a clear-complete write lowers it.
- R11: With `PAD_MODE` set, the end address is the limit with bit 31 cleared, minus 15. The limit register still reads back the raw value.
- R12: A control write carrying reset while a transfer is in flight removes `mem_req` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level completion interrupt |
| mem_req | output | 1 | Memory word request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_we | output | 1 | Request is a memory write |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_err | input | 1 | Memory signals a bus error on the current request |
| dev_rx_data | input | 32 | Word offered by the device |
| dev_rx_take | output | 1 | Device word consumed this cycle |
| dev_tx_data | output | 32 | Word delivered to the device |
| dev_tx_valid | output | 1 | `dev_tx_data` is valid this cycle |

## Verification
The embedded properties watch the per-cycle rules on every clock. These are the pointer step after an accepted word, the reload from the follow-on pair, shutdown on an unarmed finish, the bus-error stop, reset overriding set commands, the one-cycle delivery of read data to the device, and the interrupt rising only while enabled. Other behaviour only shows up across whole scenarios: the exact address and data order across a chain switch, the full set of state left behind after each kind of termination, shadow registers shifting on a switch, the alias clearing an earlier exception, and the padding arithmetic of the second variant. The scoreboard bench covers these, with memory stalls used to freeze the channel just after a switch.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  // address register indices inside the register bank
  localparam int unsigned NUM_AREGS = 8;
  localparam int unsigned IX_NEXT   = 0;
  localparam int unsigned IX_LIMIT  = 1;
  localparam int unsigned IX_START  = 2;
  localparam int unsigned IX_STOP   = 3;
  localparam int unsigned IX_SNEXT  = 4;
  localparam int unsigned IX_SLIMIT = 5;
  localparam int unsigned IX_SSTART = 6;
  localparam int unsigned IX_SSTOP  = 7;

  // control word command bits
  localparam int unsigned CMD_W        = 7;
  localparam int unsigned CMD_SET_EN   = 0;
  localparam int unsigned CMD_ARM      = 1;
  localparam int unsigned CMD_CLR_CMPL = 2;
  localparam int unsigned CMD_RESET    = 3;
  localparam int unsigned CMD_INIT     = 4;
  localparam int unsigned CMD_SET_RD   = 5;
  localparam int unsigned CMD_SET_WR   = 6;

  // register map
  localparam logic [3:0]  OFS_CSR       = 4'd0;
  localparam logic [3:0]  OFS_ALIAS     = 4'd9;
  localparam int unsigned OFS_AREG_BASE = 1;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned PAD_BYTES  = 15;

  // status word, bit 0 is enable
  typedef struct packed {
    logic rd_dir;
    logic bus_exc;
    logic complete;
    logic chain_arm;
    logic enable;
  } chan_stat_t;

endpackage

// File: rtl/dma_addr_regs.sv
module dma_addr_regs
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_AREGS-1:0]               sw_we,
  input  logic [AW-1:0]                      sw_wdata,
  input  logic                               hw_adv,
  input  logic                               hw_reload,
  output logic [NUM_AREGS-1:0][AW-1:0]       regs_q
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [NUM_AREGS-1:0][AW-1:0] regs_d;
  logic [NUM_AREGS-1:0]         load_en;

  // next-state: hardware updates first, software writes take precedence
  always_comb begin
    regs_d  = regs_q;
    load_en = sw_we;
    if (hw_adv) begin
      regs_d[IX_NEXT]  = regs_q[IX_NEXT] + STEP;
      load_en[IX_NEXT] = 1'b1;
    end
    if (hw_reload) begin
      regs_d[IX_NEXT]    = regs_q[IX_START];
      regs_d[IX_LIMIT]   = regs_q[IX_STOP];
      regs_d[IX_SNEXT]   = regs_q[IX_SSTART];
      regs_d[IX_SLIMIT]  = regs_q[IX_SSTOP];
      load_en[IX_NEXT]   = 1'b1;
      load_en[IX_LIMIT]  = 1'b1;
      load_en[IX_SNEXT]  = 1'b1;
      load_en[IX_SLIMIT] = 1'b1;
    end
    for (int i = 0; i < NUM_AREGS; i++) begin
      if (sw_we[i]) regs_d[i] = sw_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NUM_AREGS; i++) begin
        if (load_en[i]) regs_q[i] <= regs_d[i];
      end
    end
  end

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_adv && !sw_we[IX_NEXT]) |=> regs_q[IX_NEXT] == $past(regs_q[IX_NEXT]) + STEP);

  // R7
  reload_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reload && !sw_we[IX_NEXT] && !sw_we[IX_START])
      |=> regs_q[IX_NEXT] == $past(regs_q[IX_START]));

  // R2
  limit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we[IX_LIMIT] |=> regs_q[IX_LIMIT] == $past(sw_wdata));

endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [CMD_W-1:0] csr_cmd,
  input  logic             alias_init,
  input  logic             at_end,
  input  logic             bus_err_evt,
  output chan_stat_t       stat_q,
  output logic             hw_reload
);

  chan_stat_t stat_d;
  logic       fin_evt;
  logic       init_act;
  logic       hw_set;

  assign fin_evt   = stat_q.enable & at_end;
  assign hw_reload = fin_evt & stat_q.chain_arm;
  assign init_act  = (csr_we & csr_cmd[CMD_INIT]) | alias_init;
  assign hw_set    = fin_evt | bus_err_evt;

  always_comb begin
    stat_d = stat_q;
    // hardware events
    if (bus_err_evt) begin
      stat_d.enable   = 1'b0;
      stat_d.complete = 1'b1;
      stat_d.bus_exc  = 1'b1;
    end else if (fin_evt) begin
      stat_d.complete = 1'b1;
      if (stat_q.chain_arm) stat_d.chain_arm = 1'b0;
      else                  stat_d.enable    = 1'b0;
    end
    // software commands
    if (init_act && !bus_err_evt) stat_d.bus_exc = 1'b0;
    if (csr_we) begin
      if (csr_cmd[CMD_CLR_CMPL] && !hw_set) stat_d.complete = 1'b0;
      if (csr_cmd[CMD_SET_RD])      stat_d.rd_dir = 1'b1;
      else if (csr_cmd[CMD_SET_WR]) stat_d.rd_dir = 1'b0;
      if (csr_cmd[CMD_RESET]) begin
        stat_d.enable    = 1'b0;
        stat_d.chain_arm = 1'b0;
        stat_d.complete  = 1'b0;
      end else begin
        if (csr_cmd[CMD_SET_EN]) stat_d.enable    = 1'b1;
        if (csr_cmd[CMD_ARM])    stat_d.chain_arm = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // R4
  rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_cmd[CMD_RESET]) |=> (!stat_q.enable && !stat_q.chain_arm && !stat_q.complete));

  // R8
  stop_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && !stat_q.chain_arm && !csr_we) |=> (!stat_q.enable && stat_q.complete));

  // R7
  chain_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && stat_q.chain_arm && !csr_we) |=> (stat_q.enable && !stat_q.chain_arm && stat_q.complete));

  // R9
  berr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_evt && !csr_we) |=> (stat_q.bus_exc && stat_q.complete && !stat_q.enable));

endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter bit          PAD_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rd_dir,
  input  logic [AW-1:0] next_addr,
  input  logic [AW-1:0] limit_addr,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  input  logic [31:0]   dev_rx_data,
  output logic          at_end,
  output logic          accept,
  output logic          bus_err_evt,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  output logic          dev_rx_take,
  output logic [31:0]   dev_tx_data,
  output logic          dev_tx_valid
);

  logic [AW-1:0] end_addr;
  logic [31:0]   tx_data_d;
  logic          tx_valid_d;
  logic          tx_load;

  generate
    if (PAD_MODE) begin : g_pad
      assign end_addr = {1'b0, limit_addr[AW-2:0]} - AW'(PAD_BYTES);
    end else begin : g_plain
      assign end_addr = limit_addr;
    end
  endgenerate

  assign at_end      = (next_addr == end_addr);
  assign mem_req     = enable & ~at_end;
  assign mem_addr    = next_addr;
  assign mem_we      = rd_dir;
  assign mem_wdata   = dev_rx_data;
  assign bus_err_evt = mem_req & mem_err;
  assign accept      = mem_req & mem_ack & ~mem_err;
  assign dev_rx_take = accept & rd_dir;

  assign tx_load = accept & ~rd_dir;

  always_comb begin
    tx_valid_d = tx_load;
    tx_data_d  = tx_load ? mem_rdata : dev_tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_tx_valid <= 1'b0;
      dev_tx_data  <= '0;
    end else begin
      dev_tx_valid <= tx_valid_d;
      if (tx_load) dev_tx_data <= tx_data_d;
    end
  end

  // R6
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (dev_tx_valid && dev_tx_data == $past(mem_rdata)));

  // R6
  rx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rx_take |-> (mem_we && mem_req));

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter bit          PAD_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   dev_rx_data,
  output logic          dev_rx_take,
  output logic [31:0]   dev_tx_data,
  output logic          dev_tx_valid
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic                         csr_we;
  logic                         alias_we;
  logic [NUM_AREGS-1:0]         sw_we;
  logic [NUM_AREGS-1:0][AW-1:0] regs_q;
  chan_stat_t                   stat_q;
  logic                         hw_reload;
  logic                         at_end;
  logic                         accept;
  logic                         bus_err_evt;
  logic                         en_w;

  // register bus decode
  always_comb begin
    csr_we   = reg_we && (reg_addr == OFS_CSR);
    alias_we = reg_we && (reg_addr == OFS_ALIAS);
    for (int i = 0; i < NUM_AREGS; i++) begin
      sw_we[i] = reg_we && (reg_addr == 4'(i + OFS_AREG_BASE));
    end
    sw_we[IX_NEXT] = sw_we[IX_NEXT] | alias_we;
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CSR) begin
      reg_rdata = 32'(stat_q);
    end else if (reg_addr == OFS_ALIAS) begin
      reg_rdata = 32'(regs_q[IX_NEXT]);
    end else begin
      for (int i = 0; i < NUM_AREGS; i++) begin
        if (reg_addr == 4'(i + OFS_AREG_BASE)) reg_rdata = 32'(regs_q[i]);
      end
    end
  end

  dma_addr_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .sw_we     (sw_we),
    .sw_wdata  (reg_wdata[AW-1:0]),
    .hw_adv    (accept),
    .hw_reload (hw_reload),
    .regs_q    (regs_q)
  );

  dma_csr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_ni),
    .csr_we      (csr_we),
    .csr_cmd     (reg_wdata[CMD_W-1:0]),
    .alias_init  (alias_we),
    .at_end      (at_end),
    .bus_err_evt (bus_err_evt),
    .stat_q      (stat_q),
    .hw_reload   (hw_reload)
  );

  dma_word_mover #(.AW(AW), .PAD_MODE(PAD_MODE)) u_mover (
    .clk          (clk),
    .rst_n        (rst_ni),
    .enable       (stat_q.enable),
    .rd_dir       (stat_q.rd_dir),
    .next_addr    (regs_q[IX_NEXT]),
    .limit_addr   (regs_q[IX_LIMIT]),
    .mem_ack      (mem_ack),
    .mem_err      (mem_err),
    .mem_rdata    (mem_rdata),
    .dev_rx_data  (dev_rx_data),
    .at_end       (at_end),
    .accept       (accept),
    .bus_err_evt  (bus_err_evt),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .dev_rx_take  (dev_rx_take),
    .dev_tx_data  (dev_tx_data),
    .dev_tx_valid (dev_tx_valid)
  );

  assign irq  = stat_q.complete;
  assign en_w = stat_q.enable;

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> $past(en_w));

  // R3
  alias_init_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (alias_we && !bus_err_evt) |=> !stat_q.bus_exc);

  // R12
  stop_req_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_we && reg_wdata[CMD_RESET]) |=> !mem_req);

endmodule

// File: tb/sim_dma_chain_chan.sv
module sim_dma_chain_chan;

  localparam logic [31:0] C_EN = 32'h01, C_ARM = 32'h02, C_CLR = 32'h04, C_RST = 32'h08,
                          C_INIT = 32'h10, C_RD = 32'h20, C_WR = 32'h40;
  localparam logic [31:0] S_EN = 32'h01, S_ARM = 32'h02, S_CMPL = 32'h04, S_BX = 32'h08, S_RD = 32'h10;
  localparam logic [31:0] PAT = 32'h5A00_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wen0 = 1'b0, wen1 = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  logic        req0, req1, we0, we1, ack0, ack1, err0;
  logic [31:0] addr0, addr1, wdata0, wdata1, mrd0, mrd1;
  logic        take0, take1, txv0, txv1;
  logic [31:0] txd0, txd1;
  logic [31:0] rx_word = 32'hC000_0000;
  logic        hold = 1'b0;
  logic [31:0] hold_from = '0;
  logic        err_arm = 1'b0;
  logic [31:0] err_addr = '0;

  assign err0 = err_arm && req0 && (addr0 == err_addr);
  assign ack0 = !(hold && (addr0 >= hold_from)) && !err0;
  assign ack1 = 1'b1;
  assign mrd0 = addr0 ^ PAT;
  assign mrd1 = addr1 ^ PAT;

  dma_chain_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(wen0), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata0), .irq(irq0), .mem_req(req0), .mem_addr(addr0), .mem_we(we0),
    .mem_wdata(wdata0), .mem_rdata(mrd0), .mem_ack(ack0), .mem_err(err0),
    .dev_rx_data(rx_word), .dev_rx_take(take0), .dev_tx_data(txd0), .dev_tx_valid(txv0));

  dma_chain_chan #(.PAD_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_we(wen1), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .irq(irq1), .mem_req(req1), .mem_addr(addr1), .mem_we(we1),
    .mem_wdata(wdata1), .mem_rdata(mrd1), .mem_ack(ack1), .mem_err(1'b0),
    .dev_rx_data(rx_word), .dev_rx_take(take1), .dev_tx_data(txd1), .dev_tx_valid(txv1));

  int n_chk = 0;
  int n_err = 0;
  int u1_cnt = 0;
  bit done = 1'b0;

  typedef struct packed { logic [31:0] a; logic we; logic [31:0] d; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int inst, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d;
    wen0 = (inst == 0); wen1 = (inst == 1);
    @(negedge clk);
    wen0 = 1'b0; wen1 = 1'b0;
  endtask

  task automatic rd(input int inst, input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = (inst == 0) ? rdata0 : rdata1;
  endtask

  task automatic prog(input int inst, input logic [31:0] dir, input logic [31:0] nx, input logic [31:0] lim,
                      input logic [31:0] st, input logic [31:0] sp);
    wr(inst, 4'd0, 32'h0);
    wr(inst, 4'd0, C_INIT | C_RST | dir);
    wr(inst, 4'd1, nx);  wr(inst, 4'd2, lim);
    wr(inst, 4'd5, nx);  wr(inst, 4'd6, lim);
    wr(inst, 4'd3, st);  wr(inst, 4'd4, sp);
    wr(inst, 4'd7, st);  wr(inst, 4'd8, sp);
  endtask

  // driver side of the scoreboard
  task automatic push_mrd(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) sb_q.push_back('{a: a + 32'(4*i), we: 1'b0, d: (a + 32'(4*i)) ^ PAT});
  endtask

  task automatic push_mwr(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) sb_q.push_back('{a: a + 32'(4*i), we: 1'b1, d: rx_word + 32'(i)});
  endtask

  task automatic wait_irq0;
    while (!irq0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor side of the scoreboard
  bit          take_pend = 1'b0;
  bit          tx_pend = 1'b0;
  logic [31:0] tx_exp = '0;
  always @(negedge clk) begin
    if (take_pend) rx_word = rx_word + 32'd1;
    take_pend = 1'b0;
    if (tx_pend) begin
      chk("R6 tx valid", {31'b0, txv0}, 32'd1);
      chk("R6 tx data", txd0, tx_exp);
      tx_pend = 1'b0;
    end
    #2;
    if (rst_n && req0 && ack0) begin
      if (sb_q.size() == 0) begin
        chk("R5 unexpected word", addr0, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R5 word address", addr0, e.a);
        chk("R6 word direction", {31'b0, we0}, {31'b0, e.we});
        if (e.we) begin
          chk("R6 write data", wdata0, e.d);
          chk("R6 rx take", {31'b0, take0}, 32'd1);
          take_pend = 1'b1;
        end else begin
          tx_pend = 1'b1;
          tx_exp = e.d;
        end
      end
    end
    if (rst_n && req1 && ack1) u1_cnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, 4'd0, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'b0, irq0}, 32'd0);
    chk("R1 req", {31'b0, req0}, 32'd0);
    chk("R1 tx valid", {31'b0, txv0}, 32'd0);
    for (int i = 1; i <= 8; i++) begin
      rd(0, 4'(i), v); chk("R1 addr reg", v, 32'h0);
    end

    // R2 readback of every address register
    for (int i = 1; i <= 8; i++) wr(0, 4'(i), 32'h1234_0000 + 32'(i * 16));
    for (int i = 1; i <= 8; i++) begin
      rd(0, 4'(i), v); chk("R2 readback", v, 32'h1234_0000 + 32'(i * 16));
    end

    // R8 single buffer, memory to device
    prog(0, C_WR, 32'h100, 32'h110, 32'h0, 32'h0);
    push_mrd(32'h100, 4);
    wr(0, 4'd0, C_EN | C_WR);
    wait_irq0;
    rd(0, 4'd0, v); chk("R8 status after finish", v, S_CMPL);
    rd(0, 4'd1, v); chk("R8 pointer at end", v, 32'h110);
    chk("R8 no request", {31'b0, req0}, 32'd0);
    chk("R8 queue drained", 32'(sb_q.size()), 32'd0);
    chk("R10 irq high", {31'b0, irq0}, 32'd1);
    wr(0, 4'd0, C_CLR | C_RST);
    chk("R10 irq cleared", {31'b0, irq0}, 32'd0);
    rd(0, 4'd0, v); chk("R4 status after ack", v, 32'h0);

    // R7 chained buffers, stall right after the switch
    prog(0, C_WR, 32'h200, 32'h208, 32'h300, 32'h30C);
    push_mrd(32'h200, 2);
    push_mrd(32'h300, 3);
    hold_from = 32'h300; hold = 1'b1;
    wr(0, 4'd0, C_EN | C_ARM | C_WR);
    rd(0, 4'd0, v); chk("R4 enable and arm", v & (S_EN | S_ARM), S_EN | S_ARM);
    wait_irq0;
    rd(0, 4'd0, v); chk("R7 status after switch", v, S_EN | S_CMPL);
    rd(0, 4'd1, v); chk("R7 pointer from start", v, 32'h300);
    rd(0, 4'd2, v); chk("R7 limit from stop", v, 32'h30C);
    rd(0, 4'd5, v); chk("R7 pointer shadow", v, 32'h300);
    rd(0, 4'd6, v); chk("R7 limit shadow", v, 32'h30C);
    chk("R7 request held", {31'b0, req0}, 32'd1);
    wr(0, 4'd0, C_CLR | C_WR);
    chk("R10 irq acked", {31'b0, irq0}, 32'd0);
    rd(0, 4'd0, v); chk("R4 clear complete", v, S_EN);
    hold = 1'b0;
    wait_irq0;
    rd(0, 4'd0, v); chk("R8 status after chain end", v, S_CMPL);
    rd(0, 4'd1, v); chk("R8 pointer after chain", v, 32'h30C);
    chk("R7 queue drained", 32'(sb_q.size()), 32'd0);
    wr(0, 4'd0, C_CLR | C_RST);

    // R6 device to memory
    prog(0, C_RD, 32'h400, 32'h40C, 32'h0, 32'h0);
    push_mwr(32'h400, 3);
    wr(0, 4'd0, C_EN | C_RD);
    wait_irq0;
    rd(0, 4'd0, v); chk("R6 status read dir", v, S_RD | S_CMPL);
    chk("R6 queue drained", 32'(sb_q.size()), 32'd0);
    wr(0, 4'd0, C_CLR | C_RST | C_WR);

    // R9 bus error, then R3 alias clears it
    prog(0, C_WR, 32'h500, 32'h510, 32'h0, 32'h0);
    err_addr = 32'h508; err_arm = 1'b1;
    push_mrd(32'h500, 2);
    wr(0, 4'd0, C_EN | C_WR);
    wait_irq0;
    rd(0, 4'd0, v); chk("R9 status", v, S_BX | S_CMPL);
    rd(0, 4'd1, v); chk("R9 pointer on failing word", v, 32'h508);
    chk("R9 no request", {31'b0, req0}, 32'd0);
    chk("R9 queue drained", 32'(sb_q.size()), 32'd0);
    err_arm = 1'b0;
    wr(0, 4'd9, 32'h700);
    rd(0, 4'd0, v); chk("R3 exception cleared", v, S_CMPL);
    rd(0, 4'd1, v); chk("R3 pointer via alias", v, 32'h700);
    rd(0, 4'd9, v); chk("R3 alias readback", v, 32'h700);
    wr(0, 4'd0, C_CLR);
    rd(0, 4'd0, v); chk("R4 clear only", v, 32'h0);

    // R12 reset stops an in-flight transfer; R4 reset beats set-enable
    prog(0, C_WR, 32'h800, 32'h900, 32'h0, 32'h0);
    hold_from = 32'h800; hold = 1'b1;
    wr(0, 4'd0, C_EN | C_WR);
    chk("R12 request active", {31'b0, req0}, 32'd1);
    chk("R5 request address", addr0, 32'h800);
    wr(0, 4'd0, C_CLR | C_RST);
    chk("R12 request dropped", {31'b0, req0}, 32'd0);
    rd(0, 4'd0, v); chk("R12 status", v, 32'h0);
    hold = 1'b0;
    wr(0, 4'd0, C_RST | C_EN | C_ARM);
    rd(0, 4'd0, v); chk("R4 reset overrides set", v, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 stays idle", {31'b0, req0}, 32'd0);

    // R11 padded limit on the second instance
    u1_cnt = 0;
    prog(1, C_WR, 32'h600, 32'h8000_0617, 32'h0, 32'h0);
    wr(1, 4'd0, C_EN | C_WR);
    while (!irq1) @(negedge clk);
    @(negedge clk);
    chk("R11 words moved", 32'(u1_cnt), 32'd2);
    rd(1, 4'd1, v); chk("R11 pointer end", v, 32'h608);
    rd(1, 4'd2, v); chk("R11 raw limit", v, 32'h8000_0617);
    rd(1, 4'd0, v); chk("R11 status", v, S_CMPL);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule